// File: doc/BRIEF.md
# Period-Match Timer with Prescale and Postscale

This block is an 8-bit up-counter with a programmable period. A single-cycle tick input qualifies the system clock. A prescaler with three selectable ratios divides that tick stream. The counter advances once per prescaled tick and returns to zero on the step after it equals the period value.

Each such wrap is a match event. A match is exported as a one-cycle pulse that a serial shifter can use as a bit clock. A 4-bit postscaler also counts the matches, and every Nth match sets a sticky interrupt flag.

Software loads the count, period and control values through three write strobes that share nothing. It reads them back on three plain output buses. Writes to the count or to the control value silently restart the prescaler and the postscaler.

Top module: `pm_timer`

## Requirements
- R1: While enabled, each prescaled tick advances the count by one. When the count equals the period on such a tick, the count becomes 00h instead.
- R2: After reset the count reads 00h, the period reads FFh, the control reads 00h, and the flag and match outputs are low.
- R3: Control bits 1:0 choose the prescale ratio: 00 gives one step per tick, 01 gives one step per 4 ticks, and 10 or 11 give one step per 16 ticks.
- R4: Control bits 6:3 hold a value P. The flag sets on every (P+1)th match, so 0000 gives 1:1 and 1111 gives 1:16.
- R5: The control readback has the layout {0, bits 6:3 postscale, bit 2 enable, bits 1:0 prescale}. Bit 7 always reads 0, whatever is written to it.
- R6: With enable (control bit 2) at 0 the count holds its value.
- R7: The match output is high for exactly one cycle, the cycle in which the count first reads 00h after a match.
- R8: The flag stays set until flag_clr is asserted. If a flag-setting match and flag_clr fall in the same cycle, the flag is set.
- R9: A count write loads the value at the next clock edge. No increment happens in that cycle. A control write likewise suppresses any increment in its cycle.
- R10: A write to the count or to the control clears the prescaler and the postscaler. A control write leaves the count unchanged.
- R11: A period below the current count causes no match until the count has run through FFh and wrapped to 00h. That wrap produces no match.
- R12: Without a tick the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-qualifying clock enable |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count write value |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 8 | Period write value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| flag_clr | input | 1 | Clears the interrupt flag |
| cnt_q | output | 8 | Count readback |
| per_q | output | 8 | Period readback |
| ctl_q | output | 8 | Control readback |
| match_o | output | 1 | Pre-postscaler match pulse |
| flag_o | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a flag-setting match and a flag clear. The bench provokes it with a period of zero and a 1:1 postscale, which makes every prescaled tick a flag-setting match, while it holds flag_clr high; the flag must read set on each of those cycles. It then disables the timer through a control write while the clear is still held, and the flag must drop.

The second pair is a count or control write and an increment. The bench writes while ticks are arriving and checks that the count shows exactly the written or retained value at the next edge, with no extra step.

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         per_we,
  input  logic [W-1:0] per_wdata,
  input  logic         ctl_we,
  input  logic [7:0]   ctl_wdata,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] per_q,
  output logic [7:0]   ctl_q,
  output logic         match_o,
  output logic         flag_o
);
  localparam int PRW = 4;
  localparam int PSW = 4;

  logic [W-1:0]   cnt_r, per_r;
  logic [PSW-1:0] outps_r, post_r;
  logic [1:0]     psel_r;
  logic           en_r, match_r, flag_r;
  logic [PRW-1:0] pre_r, pre_lim;

  wire wr_clr = cnt_we | ctl_we;

  always_comb begin
    case (psel_r)
      2'b00:   pre_lim = PRW'(0);
      2'b01:   pre_lim = PRW'(3);
      default: pre_lim = PRW'(15);
    endcase
  end

  wire pre_term  = (pre_r == pre_lim);
  wire step      = en_r & tick & ~wr_clr & pre_term;
  wire hit       = step & (cnt_r == per_r);
  wire post_done = hit & (post_r == outps_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_r <= '0;
    else if (wr_clr)        pre_r <= '0;
    else if (en_r && tick)  pre_r <= pre_term ? '0 : pre_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_r <= '0;
    else if (cnt_we) cnt_r <= cnt_wdata;
    else if (step)   cnt_r <= hit ? '0 : cnt_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_r <= '1;
    else if (per_we) per_r <= per_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outps_r <= '0;
      en_r    <= 1'b0;
      psel_r  <= 2'b00;
    end else if (ctl_we) begin
      outps_r <= ctl_wdata[6:3];
      en_r    <= ctl_wdata[2];
      psel_r  <= ctl_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      post_r <= '0;
    else if (wr_clr) post_r <= '0;
    else if (hit)    post_r <= post_done ? '0 : post_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_r <= 1'b0;
      flag_r  <= 1'b0;
    end else begin
      match_r <= hit;
      if (post_done)     flag_r <= 1'b1;
      else if (flag_clr) flag_r <= 1'b0;
    end
  end

  assign cnt_q   = cnt_r;
  assign per_q   = per_r;
  assign ctl_q   = {1'b0, outps_r, en_r, psel_r};
  assign match_o = match_r;
  assign flag_o  = flag_r;
endmodule

// File: rtl/pm_timer_chk.sv
module pm_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_we,
  input logic [W-1:0] cnt_wdata,
  input logic         ctl_we,
  input logic         flag_clr,
  input logic [W-1:0] cnt_q,
  input logic [7:0]   ctl_q,
  input logic         match_o,
  input logic         flag_o
);
  a_r5_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7] == 1'b0);

  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[2] && !cnt_we) |=> $stable(cnt_q));

  a_r12_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt_q));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));

  a_r10_ctl_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !cnt_we) |=> (cnt_q == $past(cnt_q)));

  a_r7_match_zero: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (cnt_q == '0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);

  a_r4_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> match_o);

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
endmodule

bind pm_timer pm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .ctl_we(ctl_we), .flag_clr(flag_clr), .cnt_q(cnt_q), .ctl_q(ctl_q),
  .match_o(match_o), .flag_o(flag_o)
);

// File: tb/sim_pm_timer.sv
`timescale 1ns/1ps
module sim_pm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       cnt_we = 1'b0, per_we = 1'b0, ctl_we = 1'b0, flag_clr = 1'b0;
  logic [7:0] cnt_wdata = '0, per_wdata = '0, ctl_wdata = '0;
  logic [7:0] cnt_q, per_q, ctl_q;
  logic       match_o, flag_o;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pm_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .per_we(per_we), .per_wdata(per_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .per_q(per_q), .ctl_q(ctl_q),
    .match_o(match_o), .flag_o(flag_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v; step(1); cnt_we = 1'b0;
  endtask
  task automatic wr_per(input logic [7:0] v);
    per_we = 1'b1; per_wdata = v; step(1); per_we = 1'b0;
  endtask
  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v; step(1); ctl_we = 1'b0;
  endtask
  task automatic clr_flag();
    wr_ctl(8'h00);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 count", cnt_q, 8'h00);
    chk("R2 period", per_q, 8'hFF);
    chk("R2 control", ctl_q, 8'h00);
    chk("R2 flag", flag_o, 1'b0);
    chk("R2 match", match_o, 1'b0);
    wr_ctl(8'h80);
    chk("R5 bit7 reads 0", ctl_q, 8'h00);
    wr_ctl(8'hFF);
    chk("R5 layout", ctl_q, 8'h7F);
    wr_ctl(8'h00);
  endtask

  task automatic t_basic();
    wr_per(8'd3); wr_cnt(8'd0);
    wr_ctl(8'h04);
    chk("R9 ctl write no step", cnt_q, 8'd0);
    step(1); chk("R1 step", cnt_q, 8'd1);
    step(2); chk("R1 reach period", cnt_q, 8'd3);
    step(1);
    chk("R1 wrap", cnt_q, 8'd0);
    chk("R7 match pulse", match_o, 1'b1);
    chk("R4 1:1 flag", flag_o, 1'b1);
    step(1);
    chk("R7 single cycle", match_o, 1'b0);
    chk("R1 after wrap", cnt_q, 8'd1);
    wr_ctl(8'h00);
    chk("R10 ctl keeps count", cnt_q, 8'd1);
    step(5); chk("R6 hold", cnt_q, 8'd1);
    chk("R8 sticky", flag_o, 1'b1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R8 clear", flag_o, 1'b0);
  endtask

  task automatic t_tick();
    wr_cnt(8'd0); wr_per(8'hFF); wr_ctl(8'h04);
    for (int i = 0; i < 3; i++) begin
      tick = 1'b0; step(1); tick = 1'b1; step(1);
    end
    chk("R12 only ticks count", cnt_q, 8'd3);
    tick = 1'b0; step(5);
    chk("R12 no tick holds", cnt_q, 8'd3);
    tick = 1'b1;
    wr_ctl(8'h00);
  endtask

  task automatic t_prescale(input logic [7:0] v, input int ratio);
    wr_ctl(8'h00); wr_per(8'd2); wr_cnt(8'd0);
    wr_ctl(v);
    step(ratio - 1); chk("R3 before terminal", cnt_q, 8'd0);
    step(1);         chk("R3 terminal step", cnt_q, 8'd1);
    step(2 * ratio);
    chk("R3 wrap count", cnt_q, 8'd0);
    chk("R3 wrap match", match_o, 1'b1);
    wr_ctl(8'h00);
  endtask

  task automatic t_postscale(input logic [3:0] ps);
    clr_flag();
    wr_per(8'd0); wr_cnt(8'd0);
    wr_ctl({1'b0, ps, 1'b1, 2'b00});
    step(int'(ps));
    chk("R4 flag not yet", flag_o, 1'b0);
    chk("R7 match each step at period 0", match_o, (ps == 4'd0) ? 1'b0 : 1'b1);
    step(1);
    chk("R4 flag on Nth match", flag_o, 1'b1);
    wr_ctl(8'h00);
  endtask

  task automatic t_setwins();
    clr_flag();
    wr_per(8'd0); wr_cnt(8'd0); wr_ctl(8'h04);
    flag_clr = 1'b1;
    step(3);
    chk("R8 set beats clear", flag_o, 1'b1);
    wr_ctl(8'h00);
    chk("R8 clear when no set", flag_o, 1'b0);
    flag_clr = 1'b0;
  endtask

  task automatic t_load();
    wr_per(8'hFF); wr_cnt(8'd0); wr_ctl(8'h04);
    wr_cnt(8'h50);
    chk("R9 load no step", cnt_q, 8'h50);
    step(1); chk("R9 step after load", cnt_q, 8'h51);
    wr_ctl(8'h04);
    chk("R10 ctl keeps count", cnt_q, 8'h51);
    step(1); chk("R1 resumes", cnt_q, 8'h52);
    wr_ctl(8'h00);
    step(5); chk("R6 disabled hold", cnt_q, 8'h52);
  endtask

  task automatic t_preclr();
    wr_per(8'hFF); wr_cnt(8'd7); wr_ctl(8'h05);
    step(2);
    wr_cnt(8'd7);
    step(3); chk("R10 count write clears prescaler", cnt_q, 8'd7);
    step(1); chk("R10 full prescale after count write", cnt_q, 8'd8);
    step(2);
    wr_ctl(8'h05);
    step(3); chk("R10 ctl write clears prescaler", cnt_q, 8'd8);
    step(1); chk("R10 full prescale after ctl write", cnt_q, 8'd9);
    wr_ctl(8'h00);
  endtask

  task automatic t_postclr();
    clr_flag();
    wr_per(8'd0); wr_cnt(8'd0); wr_ctl(8'h0C);
    step(1); chk("R4 1:2 first match", flag_o, 1'b0);
    wr_cnt(8'd0);
    step(1); chk("R10 postscaler cleared", flag_o, 1'b0);
    step(1); chk("R4 1:2 second match", flag_o, 1'b1);
    wr_ctl(8'h00);
  endtask

  task automatic t_lowper();
    wr_per(8'hFF); wr_cnt(8'h10); wr_per(8'd5);
    wr_ctl(8'h04);
    step(239); chk("R11 runs to FF", cnt_q, 8'hFF);
    step(1);
    chk("R11 overflow wrap", cnt_q, 8'h00);
    chk("R11 overflow no match", match_o, 1'b0);
    step(5); chk("R11 reaches period", cnt_q, 8'd5);
    step(1);
    chk("R11 match wrap", cnt_q, 8'd0);
    chk("R11 match pulse", match_o, 1'b1);
    wr_ctl(8'h00);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_tick();
    t_prescale(8'h04, 1);
    t_prescale(8'h05, 4);
    t_prescale(8'h06, 16);
    t_prescale(8'h07, 16);
    t_postscale(4'd2);
    t_postscale(4'd15);
    t_postscale(4'd0);
    t_setwins();
    t_load();
    t_preclr();
    t_postclr();
    t_lowper();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule